// File: doc/BRIEF.md
# Serial Character Transmitter with Programmable Line Format

This block turns parallel bytes into an asynchronous serial stream on a single output line. The character layout is taken from a six-bit format word. That word sets the number of data bits (five to eight), the stop length (one, one and a half, or two bit times), whether a parity bit is present, and how that bit is formed: odd, even, always one, or always zero. Timing comes from a one-cycle enable pulse at sixteen times the baud rate. Every bit on the line lasts sixteen of these pulses.

Bytes arrive over a ready/valid handshake. The block takes a byte when the line is idle, or on the final tick of the previous frame's stop time. A producer that holds valid high therefore gets frames sent back to back with no idle gap between them. The format word and the byte are captured together at acceptance. Software may rewrite the format while a frame is on the line without disturbing that frame. A busy output shows when a frame is in progress.

Top module: `uart_fmt_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `tx_busy` is 0 and `tx_ready` is 1. Ticks without a valid byte leave the line high.
- R2: A frame begins in the clock cycle after acceptance with a start bit of 0. The data bits follow least significant bit first, then the parity bit if it is enabled, then the stop time at 1.
- R3: Format bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the selected length are never sent.
- R4: When format bit [2] is 0, the stop time is 16 ticks. When it is 1, the stop time is 32 ticks, except with a length code of 00, where it is 24 ticks.
- R5: Format bit [3] set to 1 inserts one parity bit after the data. Set to 0, it inserts none, and the frame is 16 ticks shorter.
- R6: Parity mode [5:4] = 00 makes the count of ones in the sent data plus parity odd. Mode 01 makes that count even.
- R7: Parity mode 10 always sends a parity bit of 1. Mode 11 always sends 0.
- R8: The start bit, every data bit and the parity bit each last exactly 16 ticks of `tick_16x`.
- R9: The format word and the byte are captured at acceptance. Later changes to `line_fmt` or `tx_data` have no effect on the frame in progress.
- R10: A byte is accepted only while idle or on the final stop tick. A held `tx_valid` produces frames back to back, each next acceptance coming exactly one frame length of ticks after the previous one.
- R11: `tx_busy` is 1 from the cycle after acceptance until the final stop tick of a frame with no successor. After that tick it falls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle enable at sixteen times the baud rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block takes the offered byte in this cycle |
| line_fmt | input | 6 | Format: [1:0] length, [2] stop select, [3] parity enable, [5:4] parity mode |
| txd | output | 1 | Serial line, idles high |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The hardest condition to reach is the hand-over between frames. A new byte must be taken on the very tick that ends the previous stop time, and in the same cycle the format must change to a different length, parity and stop setting. The stimulus keeps `tx_valid` high throughout and rewrites `line_fmt` and `tx_data` at the first falling edge after each acceptance. Every frame is therefore both chained to the next and exposed to a mid-frame format change. The spacing between acceptances, measured in ticks, is compared with the expected frame length for each format, including the 24-tick stop case.

// File: rtl/uart_fmt_tx_pkg.sv
package uart_fmt_tx_pkg;

    localparam int CHAR_MAX = 8;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_mode_e;

    // Packed so that its bit positions line up with the format input word.
    typedef struct packed {
        par_mode_e  par_mode;   // [5:4]
        logic       par_en;     // [3]
        logic       stop_sel;   // [2]
        logic [1:0] len_sel;    // [1:0]
    } line_fmt_t;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_val;
        stop_kind_e stop_kind;
    } frame_cfg_t;

    function automatic logic [3:0] char_bits(input logic [1:0] len_sel);
        return 4'd5 + {2'b00, len_sel};
    endfunction

    function automatic logic [CHAR_MAX-1:0] keep_low(input logic [CHAR_MAX-1:0] d,
                                                     input logic [3:0] n);
        logic [CHAR_MAX-1:0] m;
        for (int i = 0; i < CHAR_MAX; i++) m[i] = (i < int'(n));
        return d & m;
    endfunction

    function automatic logic parity_of(input par_mode_e mode,
                                       input logic [CHAR_MAX-1:0] masked);
        case (mode)
            PAR_ODD:   return ~(^masked);
            PAR_EVEN:  return ^masked;
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic stop_kind_e stop_of(input logic stop_sel, input logic [1:0] len_sel);
        if (!stop_sel)              return STOP_ONE;
        else if (len_sel == 2'b00)  return STOP_ONE_HALF;
        else                        return STOP_TWO;
    endfunction

endpackage

// File: rtl/uart_fmt_tx_setup.sv
module uart_fmt_tx_setup
    import uart_fmt_tx_pkg::*;
(
    input  line_fmt_t              fmt,
    input  logic [CHAR_MAX-1:0]    data,
    output frame_cfg_t             cfg,
    output logic [CHAR_MAX-1:0]    data_masked
);

    logic [3:0] n;

    always_comb begin
        n               = char_bits(fmt.len_sel);
        data_masked     = keep_low(data, n);
        cfg.nbits       = n;
        cfg.par_en      = fmt.par_en;
        cfg.par_val     = parity_of(fmt.par_mode, data_masked);
        cfg.stop_kind   = stop_of(fmt.stop_sel, fmt.len_sel);
    end

endmodule

// File: rtl/uart_fmt_tx_timer.sv
module uart_fmt_tx_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    assign done = tick && (cnt == limit - 1'b1);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < limit) else $error("tick counter passed its limit"); // R8

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
    import uart_fmt_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    input  logic [5:0] line_fmt,
    output logic       txd,
    output logic       tx_busy
);

    localparam int CNT_W      = $clog2(2 * OVERSAMPLE + 1);
    localparam int STOP_ONE_T = OVERSAMPLE;
    localparam int STOP_MID_T = OVERSAMPLE + OVERSAMPLE / 2;
    localparam int STOP_TWO_T = 2 * OVERSAMPLE;

    tx_phase_e           phase_q;
    frame_cfg_t          cfg_q;
    logic [CHAR_MAX-1:0] shreg_q;
    logic [2:0]          bit_idx_q;

    frame_cfg_t          cfg_new;
    logic [CHAR_MAX-1:0] data_new;
    logic [CNT_W-1:0]    limit;
    logic                bit_done;
    logic                frame_end;
    logic                accept;
    logic                idle;

    uart_fmt_tx_setup u_setup (
        .fmt         (line_fmt_t'(line_fmt)),
        .data        (tx_data),
        .cfg         (cfg_new),
        .data_masked (data_new)
    );

    always_comb begin
        if (phase_q == PH_STOP) begin
            case (cfg_q.stop_kind)
                STOP_ONE_HALF: limit = CNT_W'(STOP_MID_T);
                STOP_TWO:      limit = CNT_W'(STOP_TWO_T);
                default:       limit = CNT_W'(STOP_ONE_T);
            endcase
        end else begin
            limit = CNT_W'(OVERSAMPLE);
        end
    end

    logic timer_done;

    uart_fmt_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (accept || bit_done || idle),
        .tick    (tick_16x),
        .limit   (limit),
        .done    (timer_done)
    );

    assign idle      = (phase_q == PH_IDLE);
    assign bit_done  = timer_done && !idle;
    assign frame_end = (phase_q == PH_STOP) && bit_done;
    assign tx_ready  = idle || frame_end;
    assign accept    = tx_valid && tx_ready;
    assign tx_busy   = !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cfg_q     <= '0;
            shreg_q   <= '0;
            bit_idx_q <= '0;
        end else if (accept) begin
            phase_q   <= PH_START;
            cfg_q     <= cfg_new;
            shreg_q   <= data_new;
            bit_idx_q <= '0;
        end else if (bit_done) begin
            case (phase_q)
                PH_START: phase_q <= PH_DATA;
                PH_DATA: begin
                    shreg_q   <= shreg_q >> 1;
                    bit_idx_q <= bit_idx_q + 3'd1;
                    if ({1'b0, bit_idx_q} == cfg_q.nbits - 4'd1)
                        phase_q <= cfg_q.par_en ? PH_PARITY : PH_STOP;
                end
                PH_PARITY: phase_q <= PH_STOP;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase_q)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = shreg_q[0];
            PH_PARITY: txd = cfg_q.par_val;
            default:   txd = 1'b1;
        endcase
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!txd && tx_busy)) else $error("no start bit after accept"); // R2

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !tx_valid) |=> (!tx_busy && txd)) else $error("line not idle after frame"); // R11

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !accept) |=> $stable(cfg_q)) else $error("format changed mid-frame"); // R9

    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STOP && !bit_done) |=> (phase_q != PH_START)) else $error("frame restarted early"); // R10

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA) |-> ({1'b0, bit_idx_q} < cfg_q.nbits)) else $error("data index overrun"); // R3

endmodule

// File: tb/uart_fmt_tx_tb.sv
module uart_fmt_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // {mode[5:4], par_en[3], stop[2], len[1:0]}, data
    localparam logic [13:0] VECS [NV] = '{
        {2'b00, 1'b0, 1'b0, 2'b11, 8'hA5},
        {2'b00, 1'b1, 1'b0, 2'b11, 8'h37},
        {2'b01, 1'b1, 1'b0, 2'b11, 8'h37},
        {2'b10, 1'b1, 1'b1, 2'b10, 8'hF0},
        {2'b11, 1'b1, 1'b0, 2'b01, 8'h3F},
        {2'b00, 1'b0, 1'b1, 2'b00, 8'h1B},
        {2'b01, 1'b1, 1'b1, 2'b00, 8'h15},
        {2'b00, 1'b1, 1'b1, 2'b11, 8'h00},
        {2'b01, 1'b1, 1'b0, 2'b10, 8'hFF},
        {2'b00, 1'b0, 1'b0, 2'b00, 8'hE3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [5:0] line_fmt = 6'h00;
    logic       txd;
    logic       tx_busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tick_total = 0;
    int acc_cnt = 0;
    int acc_tick [NV+1];
    logic [1:0] tdiv = 2'd0;

    uart_fmt_tx u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick_16x (tick_16x),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .line_fmt (line_fmt),
        .txd      (txd),
        .tx_busy  (tx_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tdiv     <= tdiv + 2'd1;
        tick_16x <= (tdiv == 2'd3);
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (tick_16x) tick_total <= tick_total + 1;
            if (tx_valid && tx_ready) begin
                if (acc_cnt <= NV) acc_tick[acc_cnt] <= tick_total + (tick_16x ? 1 : 0);
                acc_cnt <= acc_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks_to(input int t);
        while (tick_total < t) @(negedge clk);
    endtask

    function automatic int nbits_of(input logic [5:0] f);
        return 5 + int'(f[1:0]);
    endfunction

    function automatic int stop_len(input logic [5:0] f);
        if (!f[2]) return 16;
        return (f[1:0] == 2'b00) ? 24 : 32;
    endfunction

    function automatic int frame_len(input logic [5:0] f);
        return 16 * (1 + nbits_of(f) + int'(f[3])) + stop_len(f);
    endfunction

    function automatic logic par_exp(input logic [5:0] f, input logic [7:0] d);
        int ones = 0;
        for (int k = 0; k < nbits_of(f); k++) ones += int'(d[k]);
        case (f[5:4])
            2'b00:   return (ones % 2) == 0;
            2'b01:   return (ones % 2) == 1;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_all();
        for (int i = 0; i < NV; i++) begin
            line_fmt = VECS[i][13:8];
            tx_data  = VECS[i][7:0];
            tx_valid = 1'b1;
            while (acc_cnt <= i) @(negedge clk);
            // new format and data appear right away, mid-frame (R9)
        end
        tx_valid = 1'b0;
        line_fmt = 6'b111111;
        tx_data  = 8'h00;
    endtask

    task automatic check_all();
        for (int i = 0; i < NV; i++) begin
            logic [5:0] f = VECS[i][13:8];
            logic [7:0] d = VECS[i][7:0];
            int base;
            int n = nbits_of(f);
            while (acc_cnt <= i) @(negedge clk);
            base = acc_tick[i];
            wait_ticks_to(base + 8);
            chk("R2 start bit", int'(txd), 0);
            chk("R11 busy during frame", int'(tx_busy), 1);
            for (int j = 0; j < n; j++) begin
                wait_ticks_to(base + 16 * (1 + j) + 8);
                chk("R3 R9 data bit", int'(txd), int'(d[j]));
            end
            if (f[3]) begin
                wait_ticks_to(base + 16 * (1 + n) + 8);
                if (f[5]) chk("R5 R7 stick parity", int'(txd), int'(par_exp(f, d)));
                else      chk("R5 R6 parity", int'(txd), int'(par_exp(f, d)));
            end
            wait_ticks_to(base + 16 * (1 + n + int'(f[3])) + 8);
            chk("R2 R4 stop high", int'(txd), 1);
            if (stop_len(f) == 32) begin
                wait_ticks_to(base + 16 * (1 + n + int'(f[3])) + 24);
                chk("R4 second stop high", int'(txd), 1);
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset busy", int'(tx_busy), 0);
        chk("R1 reset ready", int'(tx_ready), 1);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        chk("R1 idle with ticks txd", int'(txd), 1);
        chk("R1 idle with ticks busy", int'(tx_busy), 0);

        fork
            drive_all();
            check_all();
        join

        for (int i = 0; i < NV - 1; i++)
            chk("R4 R5 R8 R10 frame spacing", acc_tick[i+1] - acc_tick[i],
                frame_len(VECS[i][13:8]));

        wait_ticks_to(acc_tick[NV-1] + frame_len(VECS[NV-1][13:8]) - 1);
        chk("R11 busy before last stop tick", int'(tx_busy), 1);
        wait_ticks_to(acc_tick[NV-1] + frame_len(VECS[NV-1][13:8]));
        chk("R11 busy cleared after frame", int'(tx_busy), 0);
        chk("R1 line high after frame", int'(txd), 1);
        repeat (100) @(negedge clk);
        chk("R10 accept count", acc_cnt, NV);
        chk("R1 idle after run", int'(txd), 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule